// File: doc/BRIEF.md
# Prescaled Multi-Channel PWM Controller

This block generates several independent pulse-width-modulated outputs from one shared source clock. Each channel owns a 32-bit configuration word on a simple memory-mapped bus. The word holds an enable flag, a full-duty override flag, an 8-bit duty value and a 13-bit divider. The source clock is first divided by the divider value plus one to form a tick. An 8-bit tick counter then walks through 256 ticks per output period. The output is active while the tick count is below the duty value.

Software writes a whole channel word in one single-cycle strobe. The new value takes effect on the next cycle: the channel's prescaler and tick counter restart from zero, and the period then running is abandoned. Clearing the enable flag forces the output low at once and holds the counters at zero. Re-enabling therefore always starts a fresh period from tick 0. Reads are combinational and return the stored word with every unused bit reading zero.

Top module: `pwmc_top`

## Requirements
- R1: After reset every output is low and every channel word reads back as zero.
- R2: A read of a channel word returns the last value written to it, keeping bit 31 (enable), bit 24 (full duty), bits [23:16] (duty) and bits [12:0] (divider), with bits [30:25] and [15:13] read as zero. A read of an unmapped address returns zero.
- R3: While a channel is enabled, its tick counter advances once every divider+1 clock cycles and wraps after 256 ticks. The output is high for the first duty×(divider+1) cycles of each 256×(divider+1)-cycle period, counted from the cycle after the last write to that channel.
- R4: An enabled channel with duty 0 and the full-duty flag clear keeps its output low for the whole period.
- R5: An enabled channel with the full-duty flag set keeps its output high continuously, whatever the duty field holds.
- R6: A write that clears the enable flag drives the output low in the very next cycle, without finishing the period. A later write that sets the flag again starts a new period at tick 0.
- R7: A write to a running channel applies the new word in the next cycle and restarts that channel's period from tick 0.
- R8: A write to one channel leaves the outputs, the period phase and the stored word of every other channel unchanged.
- R9: Channel n is decoded at byte offset n×16. A write whose low four address bits are not zero, or whose slot number is not below the channel count, changes no stored word and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | ADDR_W | Byte address for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
The bench goes after four edges of this block. Duty 255 at the fastest divider must leave exactly one low cycle per period; a comparator using less-or-equal would never go low there. The full-duty flag is tested with a nonzero duty value, because a design that ignored the flag would still pulse. A disable and a reconfiguration are both issued mid-period and the output is scored from the very next cycle. A design that waited for the period to end, or that kept the old counter phase, drifts away from the expected waveform. Misaligned and out-of-range writes are sent while other channels run, so a loose address decode shows up as a corrupted word or as a restarted neighbour.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

    localparam int WORD_W   = 32;
    localparam int DIV_W    = 13;
    localparam int DUTY_W   = 8;
    localparam int EN_BIT   = 31;
    localparam int FULL_BIT = 24;
    localparam int DUTY_LSB = 16;

    typedef struct packed {
        logic              en;
        logic              full;
        logic [DUTY_W-1:0] duty;
        logic [DIV_W-1:0]  div;
    } cfg_t;

    function automatic cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
        cfg_t c;
        c.en   = w[EN_BIT];
        c.full = w[FULL_BIT];
        c.duty = w[DUTY_LSB +: DUTY_W];
        c.div  = w[DIV_W-1:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_to_word(input cfg_t c);
        logic [WORD_W-1:0] w;
        w                      = '0;
        w[EN_BIT]              = c.en;
        w[FULL_BIT]            = c.full;
        w[DUTY_LSB +: DUTY_W]  = c.duty;
        w[DIV_W-1:0]           = c.div;
        return w;
    endfunction

endpackage

// File: rtl/pwmc_regs.sv
module pwmc_regs
    import pwmc_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [WORD_W-1:0]          wdata,
    output logic [WORD_W-1:0]          rdata,
    output cfg_t [NUM_CH-1:0]          cfg_o,
    output logic [NUM_CH-1:0]          hit_o
);

    localparam int SLOT_W = ADDR_W - 4;

    typedef struct packed {
        cfg_t [NUM_CH-1:0] cfg;
    } regs_t;

    regs_t              st_d, st_q;
    logic [SLOT_W-1:0]  slot;
    logic               aligned;
    logic               in_range;
    logic [NUM_CH-1:0]  hit;

    assign slot     = addr[ADDR_W-1:4];
    assign aligned  = (addr[3:0] == 4'd0);
    assign in_range = (32'(slot) < 32'(NUM_CH));

    always_comb begin
        st_d  = st_q;
        hit   = '0;
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (aligned && in_range && (slot == SLOT_W'(c))) begin
                rdata  = cfg_to_word(st_q.cfg[c]);
                hit[c] = wr_en;
                if (wr_en) begin
                    st_d.cfg[c] = word_to_cfg(wdata);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.cfg;
    assign hit_o = hit;

    assert_one_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[15:13] == 3'b000) && (rdata[30:25] == 6'b000000));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |=> (st_q.cfg[g] == word_to_cfg($past(wdata))));
        assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !hit[g] |=> $stable(st_q.cfg[g]));
    end

endmodule

// File: rtl/pwmc_chan.sv
module pwmc_chan
    import pwmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cfg_t cfg_i,
    input  logic restart_i,
    output logic pwm_o
);

    typedef struct packed {
        logic [DIV_W-1:0]  presc;
        logic [DUTY_W-1:0] tick;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!cfg_i.en || restart_i) begin
            st_d = '0;
        end else if (st_q.presc == cfg_i.div) begin
            st_d.presc = '0;
            st_d.tick  = st_q.tick + DUTY_W'(1);
        end else begin
            st_d.presc = st_q.presc + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_o = cfg_i.en && (cfg_i.full || (st_q.tick < cfg_i.duty));

    assert_presc_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_i.en |-> (st_q.presc <= cfg_i.div));

    assert_tick_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.en && !restart_i && (st_q.presc != cfg_i.div)) |=> (st_q.tick == $past(st_q.tick)));

    assert_disabled_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i.en |-> ((st_q.presc == '0) && (st_q.tick == '0)));

    assert_restart_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> ((st_q.presc == '0) && (st_q.tick == '0)));

endmodule

// File: rtl/pwmc_top.sv
module pwmc_top
    import pwmc_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    cfg_t [NUM_CH-1:0] cfg;
    logic [NUM_CH-1:0] hit;

    pwmc_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .cfg_o (cfg),
        .hit_o (hit)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwmc_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_i     (cfg[g]),
            .restart_i (hit[g]),
            .pwm_o     (pwm_out[g])
        );
    end

endmodule

// File: tb/pwmc_top_test.sv
module pwmc_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 4;
    localparam int ADDR_W     = 8;
    localparam logic [31:0] KEEP_MASK = 32'h81FF_1FFF;

    logic              clk   = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr  = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [NUM_CH-1:0] pwm_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwmc_top #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    int cyc    = 0;
    int checks = 0;
    int errors = 0;

    always @(posedge clk) cyc <= cyc + 1;

    logic [31:0] ref_cfg [NUM_CH];
    int          start_cyc [NUM_CH];

    typedef struct {
        int                cyc;
        logic [NUM_CH-1:0] exp;
        string             tag;
    } item_t;

    item_t sb[$];

    function automatic logic exp_bit(int ch, int c);
        logic [31:0] w;
        int per;
        int tick;
        w = ref_cfg[ch];
        if (!w[31]) return 1'b0;
        per  = int'(w[12:0]) + 1;
        tick = ((c - start_cyc[ch]) / per) % 256;
        return w[24] || (tick < int'(w[23:16]));
    endfunction

    // monitor: pops one expected output vector per cycle
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (pwm_out !== it.exp) begin
                errors++;
                $display("FAIL %s cycle %0d: pwm_out=%b expected %b", it.tag, it.cyc, pwm_out, it.exp);
            end
        end
    end

    // driver: schedule n cycles of expectations starting at the current cycle
    task automatic expect_run(int n, string tag);
        for (int k = 0; k < n; k++) begin
            item_t it;
            it.cyc = cyc + k;
            it.tag = tag;
            for (int ch = 0; ch < NUM_CH; ch++) it.exp[ch] = exp_bit(ch, cyc + k);
            sb.push_back(it);
        end
        while (sb.size() != 0) @(posedge clk);
        #1;
    endtask

    task automatic bus_write(logic [ADDR_W-1:0] a, logic [31:0] d);
        int slot;
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        slot  = int'(a >> 4);
        if (a[3:0] == 4'd0 && slot < NUM_CH) begin
            ref_cfg[slot]   = d & KEEP_MASK;
            start_cyc[slot] = cyc;
        end
    endtask

    task automatic check_read(logic [ADDR_W-1:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        addr = a;
        #1;
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s addr %0h: rdata=%h expected %h", tag, a, rdata, exp);
        end
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run still active, expected completion");
        finish_run();
    end

    initial begin
        for (int ch = 0; ch < NUM_CH; ch++) begin
            ref_cfg[ch]   = '0;
            start_cyc[ch] = 0;
        end
        repeat (5) @(posedge clk);
        #1;
        // R1: reset state
        checks++;
        if (pwm_out !== '0) begin
            errors++;
            $display("FAIL R1: pwm_out=%b expected 0", pwm_out);
        end
        for (int ch = 0; ch < NUM_CH; ch++) check_read(ADDR_W'(ch * 16), 32'h0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        expect_run(20, "R1");

        // R3: basic waveform, fastest divider, duty 64
        bus_write(8'h00, 32'h8040_0000);
        expect_run(600, "R3");

        // R2: readback masking, unmapped reads
        bus_write(8'h10, 32'h7EFF_E005);
        check_read(8'h10, 32'h00FF_0005, "R2");
        check_read(8'h40, 32'h0, "R2");
        check_read(8'h14, 32'h0, "R2");

        // R3 + R8: divider 2 on channel 1 while channel 0 keeps its phase
        bus_write(8'h10, 32'h8003_0002);
        expect_run(820, "R3_R8");

        // R4: duty zero stays low
        bus_write(8'h20, 32'h8000_0000);
        expect_run(300, "R4");

        // R5: full-duty flag with nonzero duty
        bus_write(8'h30, 32'h8105_0001);
        expect_run(600, "R5");
        check_read(8'h30, 32'h8105_0001, "R5");

        // R3: duty 255 boundary, single low cycle per period
        bus_write(8'h20, 32'h80FF_0000);
        expect_run(520, "R3");

        // R6: abrupt disable mid-period, then re-enable from tick 0
        bus_write(8'h00, 32'h0040_0000);
        expect_run(50, "R6");
        bus_write(8'h00, 32'h8040_0000);
        expect_run(300, "R6");

        // R7: reconfigure a running channel mid-period
        expect_run(37, "R7");
        bus_write(8'h10, 32'h8080_0001);
        expect_run(600, "R7");

        // R9: misaligned and out-of-range writes change nothing
        bus_write(8'h14, 32'h8001_0000);
        bus_write(8'h40, 32'h8001_0000);
        bus_write(8'h08, 32'h0000_0000);
        expect_run(300, "R9");
        check_read(8'h10, 32'h8080_0001, "R9");
        check_read(8'h00, 32'h8040_0000, "R9");

        finish_run();
    end

endmodule